// File: doc/BRIEF.md
# Bus-Attached 32-bit Countdown Timer

This block is a general purpose timer reached through a simple register port, used here in its joined 32-bit countdown arrangement. Software writes a 32-bit reload count (built from two 16-bit halves), picks one-shot or periodic operation in the timer A mode register, and sets the enable bit in the control register. A rising edge of that enable bit restarts the count from the full reload value. Each time the count runs out, a raw status bit is set, an optional single-cycle trigger pulse is emitted, and the timer either reloads itself or stops.

Raw status is filtered by an interrupt mask to form masked status, which drives a level interrupt. Status bits are cleared by writing ones to a clear register. The register port is word addressed with separate write and read strobes. Reads are combinational, so read data is valid in the same cycle as the read strobe. One clock serves both the register port and the count.

Top module: `gptm32_top`

## Requirements
- R1: After reset every register reads 0, `irq_o` is low and `trig_o` is low.
- R2: The configuration (0x00, 3 bits), timer A mode (0x04, 8 bits), timer B mode (0x08, 8 bits), control (0x0C, 16 bits), timer B load (0x2C, 16 bits) and timer B match (0x34, 16 bits) registers read back what was written. The mask register (0x18) keeps only the bits in 0x77.
- R3: When the configuration value is below 4, a write to the A load register (0x28) puts bits 15:0 in the A half and bits 31:16 in the B half, and a read returns {B half, A half}. At 4 or above, the write touches only the A half and the read returns the A half alone. The A match register (0x30) follows the same rule, with B match as its upper half.
- R4: With configuration 0, a control write that takes bit 0 from 0 to 1 loads the reload count N ({B load, A load}), and raw status bit 0 (offset 0x1C) is set at the N-th clock edge after that write edge.
- R5: When A mode bit 0 is 0 (periodic), timeouts repeat every N cycles and control bit 0 stays 1.
- R6: When A mode bit 0 is 1 (one-shot), the timeout clears control bit 0 and no further timeout follows.
- R7: A control write that takes bit 0 from 1 to 0 stops the count, so no timeout occurs. Enabling again restarts from the full reload count.
- R8: While control bit 5 is 1, each timeout raises `trig_o` for exactly the one cycle after the timeout edge. While it is 0, `trig_o` stays low.
- R9: Masked status (0x20) reads raw status AND mask. `irq_o` is high exactly when that value is nonzero.
- R10: Every 1 bit written to the clear register (0x24) clears the matching raw status bit, and the clear register reads 0. A timeout in the same cycle as a clear of bit 0 leaves bit 0 set.
- R11: A read of an unmapped offset returns 0. Writes to unmapped offsets, or to the raw and masked status offsets, change nothing.
- R12: A reload count of 0 times out at the first edge after enabling. No count takes place while the configuration value is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register port and the count |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register byte offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, 0 when not reading |
| irq_o | output | 1 | Level interrupt, high while masked status is nonzero |
| trig_o | output | 1 | Single-cycle pulse after each timeout when enabled |

## Verification
The assertions check the following rules on every cycle:
- a trigger pulse always comes with raw bit 0 set, and only when the trigger enable was set;
- a one-shot timeout always drops the enable bit;
- a disabled timer never times out;
- a timeout that meets a clear still leaves bit 0 set;
- a clear without a timeout drops bit 0;
- a zero mask keeps the interrupt low.

Only the bench scenarios can show the following:
- the exact N-cycle spacing of timeouts after an enable edge;
- the split and joined views of the load and match halves;
- the stop-and-restart behaviour;
- the configuration gate;
- that unmapped or read-only offsets leave every register unchanged.

// File: rtl/gptm32_pkg.sv
package gptm32_pkg;

  // Register selector produced by the offset decoder
  typedef enum logic [3:0] {
    RS_NONE,
    RS_CFG,
    RS_MODE_A,
    RS_MODE_B,
    RS_CTRL,
    RS_MASK,
    RS_RAW,
    RS_MIS,
    RS_CLR,
    RS_LOAD_A,
    RS_LOAD_B,
    RS_MATCH_A,
    RS_MATCH_B
  } reg_sel_e;

  // Bits of the mask register that can be written
  localparam logic [6:0] STAT_KEEP = 7'h77;
  // Configuration values below this join the two halves
  localparam int unsigned SPLIT_LIMIT = 4;
  // Control bit positions
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_TRG_BIT = 5;

  function automatic reg_sel_e decode_off(input logic [7:0] off);
    reg_sel_e s;
    unique case (off)
      8'h00:   s = RS_CFG;
      8'h04:   s = RS_MODE_A;
      8'h08:   s = RS_MODE_B;
      8'h0C:   s = RS_CTRL;
      8'h18:   s = RS_MASK;
      8'h1C:   s = RS_RAW;
      8'h20:   s = RS_MIS;
      8'h24:   s = RS_CLR;
      8'h28:   s = RS_LOAD_A;
      8'h2C:   s = RS_LOAD_B;
      8'h30:   s = RS_MATCH_A;
      8'h34:   s = RS_MATCH_B;
      default: s = RS_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gptm32_regs.sv
module gptm32_regs
  import gptm32_pkg::*;
#(
  parameter int unsigned CFG_W  = 3,
  parameter int unsigned MODE_W = 8,
  parameter int unsigned CTRL_W = 16,
  parameter int unsigned HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  reg_sel_e            sel,
  input  logic [2*HALF_W-1:0] wdata,
  input  logic                timeout,
  output logic                joined,
  output logic                ctrl_start,
  output logic [CFG_W-1:0]    cfg_q,
  output logic [MODE_W-1:0]   mode_a_q,
  output logic [MODE_W-1:0]   mode_b_q,
  output logic [CTRL_W-1:0]   ctrl_q,
  output logic [HALF_W-1:0]   ld_a_q,
  output logic [HALF_W-1:0]   ld_b_q,
  output logic [HALF_W-1:0]   mt_a_q,
  output logic [HALF_W-1:0]   mt_b_q
);

  localparam logic [CFG_W-1:0] SPLIT_AT = CFG_W'(SPLIT_LIMIT);

  logic [CFG_W-1:0]  cfg_d;
  logic [MODE_W-1:0] mode_a_d, mode_b_d;
  logic [CTRL_W-1:0] ctrl_d;
  logic [HALF_W-1:0] ld_a_d, ld_b_d, mt_a_d, mt_b_d;
  logic              ctrl_wr;

  assign joined     = cfg_q < SPLIT_AT;
  assign ctrl_wr    = we && (sel == RS_CTRL);
  assign ctrl_start = ctrl_wr && wdata[CTRL_EN_BIT] && !ctrl_q[CTRL_EN_BIT];

  always_comb begin
    cfg_d    = cfg_q;
    mode_a_d = mode_a_q;
    mode_b_d = mode_b_q;
    ctrl_d   = ctrl_q;
    ld_a_d   = ld_a_q;
    ld_b_d   = ld_b_q;
    mt_a_d   = mt_a_q;
    mt_b_d   = mt_b_q;
    // one-shot completion drops the enable unless software writes control now
    if (timeout && mode_a_q[0] && !ctrl_wr) begin
      ctrl_d[CTRL_EN_BIT] = 1'b0;
    end
    if (we) begin
      unique case (sel)
        RS_CFG:    cfg_d    = wdata[CFG_W-1:0];
        RS_MODE_A: mode_a_d = wdata[MODE_W-1:0];
        RS_MODE_B: mode_b_d = wdata[MODE_W-1:0];
        RS_CTRL:   ctrl_d   = wdata[CTRL_W-1:0];
        RS_LOAD_A: begin
          ld_a_d = wdata[HALF_W-1:0];
          if (joined) ld_b_d = wdata[2*HALF_W-1:HALF_W];
        end
        RS_LOAD_B: ld_b_d = wdata[HALF_W-1:0];
        RS_MATCH_A: begin
          mt_a_d = wdata[HALF_W-1:0];
          if (joined) mt_b_d = wdata[2*HALF_W-1:HALF_W];
        end
        RS_MATCH_B: mt_b_d = wdata[HALF_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      mode_a_q <= '0;
      mode_b_q <= '0;
      ctrl_q   <= '0;
      ld_a_q   <= '0;
      ld_b_q   <= '0;
      mt_a_q   <= '0;
      mt_b_q   <= '0;
    end else begin
      cfg_q    <= cfg_d;
      mode_a_q <= mode_a_d;
      mode_b_q <= mode_b_d;
      ctrl_q   <= ctrl_d;
      ld_a_q   <= ld_a_d;
      ld_b_q   <= ld_b_d;
      mt_a_q   <= mt_a_d;
      mt_b_q   <= mt_b_d;
    end
  end

endmodule

// File: rtl/gptm32_core.sv
module gptm32_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             timeout_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  // a count of 1 (or 0) expires at the coming edge
  assign last      = cnt_q <= CNT_W'(1);
  assign timeout_o = run_i && !start_i && last;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i) begin
      cnt_d = reload_i;
    end else if (run_i) begin
      cnt_d = last ? reload_i : cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/gptm32_irq.sv
module gptm32_irq
  import gptm32_pkg::*;
#(
  parameter int unsigned STAT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] wbits,
  input  logic              timeout,
  input  logic              trig_en,
  output logic [STAT_W-1:0] raw_q,
  output logic [STAT_W-1:0] mask_q,
  output logic              irq_o,
  output logic              trig_o
);

  localparam logic [STAT_W-1:0] KEEP = STAT_W'(STAT_KEEP);

  logic [STAT_W-1:0] raw_d, mask_d;
  logic              trig_d;

  always_comb begin
    raw_d  = raw_q;
    mask_d = mask_q;
    if (clr_wr)  raw_d  = raw_d & ~wbits;
    if (timeout) raw_d[0] = 1'b1;       // set beats clear
    if (mask_wr) mask_d = wbits & KEEP;
    trig_d = timeout && trig_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
      trig_o <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
      trig_o <= trig_d;
    end
  end

  assign irq_o = |(raw_q & mask_q);

endmodule

// File: rtl/gptm32_rdmux.sv
module gptm32_rdmux
  import gptm32_pkg::*;
#(
  parameter int unsigned CFG_W  = 3,
  parameter int unsigned MODE_W = 8,
  parameter int unsigned CTRL_W = 16,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned STAT_W = 7
) (
  input  logic                re,
  input  reg_sel_e            sel,
  input  logic                joined,
  input  logic [CFG_W-1:0]    cfg,
  input  logic [MODE_W-1:0]   mode_a,
  input  logic [MODE_W-1:0]   mode_b,
  input  logic [CTRL_W-1:0]   ctrl,
  input  logic [STAT_W-1:0]   raw,
  input  logic [STAT_W-1:0]   mask,
  input  logic [HALF_W-1:0]   ld_a,
  input  logic [HALF_W-1:0]   ld_b,
  input  logic [HALF_W-1:0]   mt_a,
  input  logic [HALF_W-1:0]   mt_b,
  output logic [2*HALF_W-1:0] rdata
);

  localparam int unsigned DW = 2 * HALF_W;

  logic [DW-1:0] val;

  always_comb begin
    unique case (sel)
      RS_CFG:     val = DW'(cfg);
      RS_MODE_A:  val = DW'(mode_a);
      RS_MODE_B:  val = DW'(mode_b);
      RS_CTRL:    val = DW'(ctrl);
      RS_MASK:    val = DW'(mask);
      RS_RAW:     val = DW'(raw);
      RS_MIS:     val = DW'(raw & mask);
      RS_LOAD_A:  val = joined ? {ld_b, ld_a} : DW'(ld_a);
      RS_LOAD_B:  val = DW'(ld_b);
      RS_MATCH_A: val = joined ? {mt_b, mt_a} : DW'(mt_a);
      RS_MATCH_B: val = DW'(mt_b);
      default:    val = '0;           // clear register and holes
    endcase
  end

  assign rdata = re ? val : '0;

endmodule

// File: rtl/gptm32_top.sv
module gptm32_top
  import gptm32_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CFG_W  = 3,
  parameter int unsigned MODE_W = 8,
  parameter int unsigned CTRL_W = 16,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned STAT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  input  logic              re_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              trig_o
);

  localparam int unsigned CNT_W = 2 * HALF_W;

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rsync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  logic     in_win;
  reg_sel_e sel;
  assign in_win = (addr_i >> 8) == '0;
  assign sel    = in_win ? decode_off(addr_i[7:0]) : RS_NONE;

  logic              joined, ctrl_start, ctrl_wr, clr_wr, mask_wr;
  logic              timeout, run, ctrl_en, trig_en, oneshot;
  logic [CFG_W-1:0]  cfg_q;
  logic [MODE_W-1:0] mode_a_q, mode_b_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [HALF_W-1:0] ld_a_q, ld_b_q, mt_a_q, mt_b_q;
  logic [STAT_W-1:0] raw_q, mask_q;

  assign ctrl_wr = we_i && (sel == RS_CTRL);
  assign clr_wr  = we_i && (sel == RS_CLR);
  assign mask_wr = we_i && (sel == RS_MASK);
  assign ctrl_en = ctrl_q[CTRL_EN_BIT];
  assign trig_en = ctrl_q[CTRL_TRG_BIT];
  assign oneshot = mode_a_q[0];
  assign run     = ctrl_en && (cfg_q == '0);

  gptm32_regs #(
    .CFG_W(CFG_W), .MODE_W(MODE_W), .CTRL_W(CTRL_W), .HALF_W(HALF_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(we_i), .sel(sel), .wdata(wdata_i),
    .timeout(timeout), .joined(joined), .ctrl_start(ctrl_start),
    .cfg_q(cfg_q), .mode_a_q(mode_a_q), .mode_b_q(mode_b_q), .ctrl_q(ctrl_q),
    .ld_a_q(ld_a_q), .ld_b_q(ld_b_q), .mt_a_q(mt_a_q), .mt_b_q(mt_b_q)
  );

  gptm32_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .start_i(ctrl_start), .run_i(run),
    .reload_i({ld_b_q, ld_a_q}), .timeout_o(timeout)
  );

  gptm32_irq #(.STAT_W(STAT_W)) u_irq (
    .clk(clk), .rst_n(rst_sync_n), .mask_wr(mask_wr), .clr_wr(clr_wr),
    .wbits(wdata_i[STAT_W-1:0]), .timeout(timeout), .trig_en(trig_en),
    .raw_q(raw_q), .mask_q(mask_q), .irq_o(irq_o), .trig_o(trig_o)
  );

  gptm32_rdmux #(
    .CFG_W(CFG_W), .MODE_W(MODE_W), .CTRL_W(CTRL_W), .HALF_W(HALF_W), .STAT_W(STAT_W)
  ) u_rd (
    .re(re_i), .sel(sel), .joined(joined), .cfg(cfg_q), .mode_a(mode_a_q),
    .mode_b(mode_b_q), .ctrl(ctrl_q), .raw(raw_q), .mask(mask_q),
    .ld_a(ld_a_q), .ld_b(ld_b_q), .mt_a(mt_a_q), .mt_b(mt_b_q), .rdata(rdata_o)
  );

endmodule

// File: rtl/gptm32_chk.sv
module gptm32_chk #(
  parameter int unsigned STAT_W = 7
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              irq_o,
  input logic              trig_o,
  input logic [STAT_W-1:0] raw_q,
  input logic [STAT_W-1:0] mask_q,
  input logic              ctrl_en,
  input logic              trig_en,
  input logic              oneshot,
  input logic              timeout,
  input logic              ctrl_wr,
  input logic              clr_wr,
  input logic [31:0]       wdata_i
);

  // R8
  trig_with_status_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trig_o |-> raw_q[0]);

  // R8
  trig_gated_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trig_o |-> $past(trig_en));

  // R6
  oneshot_drop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (timeout && oneshot && !ctrl_wr) |=> !ctrl_en);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctrl_en |-> !timeout);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    timeout |=> raw_q[0]);

  // R10
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_wr && wdata_i[0] && !timeout) |=> !raw_q[0]);

  // R9
  masked_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mask_q == '0) |-> !irq_o);

  // R2
  mask_hole_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mask_q[3]);

endmodule

bind gptm32_top gptm32_chk #(.STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .irq_o(irq_o), .trig_o(trig_o),
  .raw_q(raw_q), .mask_q(mask_q), .ctrl_en(ctrl_en), .trig_en(trig_en),
  .oneshot(oneshot), .timeout(timeout), .ctrl_wr(ctrl_wr), .clr_wr(clr_wr),
  .wdata_i(wdata_i)
);

// File: tb/sim_gptm32_top.sv
`timescale 1ns/1ps
module sim_gptm32_top;

  localparam logic [7:0] A_CFG = 8'h00, A_MDA = 8'h04, A_MDB = 8'h08, A_CTL = 8'h0C;
  localparam logic [7:0] A_MSK = 8'h18, A_RAW = 8'h1C, A_MIS = 8'h20, A_CLR = 8'h24;
  localparam logic [7:0] A_LDA = 8'h28, A_LDB = 8'h2C, A_MTA = 8'h30, A_MTB = 8'h34;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        we, re;
  logic [31:0] wdata, rdata;
  logic        irq, trig;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;   // 50 MHz

  gptm32_top u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata), .irq_o(irq), .trig_o(trig)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; re = 1'b1;
    #1 d = rdata;
    re = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rdchk("R1 cfg", A_CFG, 0);   rdchk("R1 modeA", A_MDA, 0);
    rdchk("R1 modeB", A_MDB, 0); rdchk("R1 ctrl", A_CTL, 0);
    rdchk("R1 mask", A_MSK, 0);  rdchk("R1 raw", A_RAW, 0);
    rdchk("R1 loadA", A_LDA, 0); rdchk("R1 matchA", A_MTA, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 trig", {31'b0, trig}, 0);
  endtask

  task automatic t_regs;
    wr(A_CFG, 32'h5);     rdchk("R2 cfg", A_CFG, 32'h5);
    wr(A_MDA, 32'hAB);    rdchk("R2 modeA", A_MDA, 32'hAB);
    wr(A_MDB, 32'hCD);    rdchk("R2 modeB", A_MDB, 32'hCD);
    wr(A_CTL, 32'h120);   rdchk("R2 ctrl", A_CTL, 32'h120);
    wr(A_MSK, 32'hFF);    rdchk("R2 mask keeps 0x77", A_MSK, 32'h77);
    wr(A_LDB, 32'h1234);  rdchk("R2 loadB", A_LDB, 32'h1234);
    wr(A_MTB, 32'h5678);  rdchk("R2 matchB", A_MTB, 32'h5678);
    wr(A_CTL, 0); wr(A_MSK, 0); wr(A_CFG, 0); wr(A_MDA, 0); wr(A_MDB, 0);
  endtask

  task automatic t_split;
    wr(A_LDA, 32'hDEAD_BEEF);
    rdchk("R3 joined loadA", A_LDA, 32'hDEAD_BEEF);
    rdchk("R3 upper to loadB", A_LDB, 32'hDEAD);
    wr(A_MTA, 32'hCAFE_F00D);
    rdchk("R3 joined matchA", A_MTA, 32'hCAFE_F00D);
    rdchk("R3 upper to matchB", A_MTB, 32'hCAFE);
    wr(A_CFG, 32'h4);
    wr(A_LDA, 32'h1111_2222);
    rdchk("R3 split loadA", A_LDA, 32'h2222);
    rdchk("R3 split keeps loadB", A_LDB, 32'hDEAD);
    wr(A_MTA, 32'h3333_4444);
    rdchk("R3 split keeps matchB", A_MTB, 32'hCAFE);
    wr(A_CFG, 0);
  endtask

  task automatic set_reload(input logic [31:0] n);
    wr(A_LDA, n);
  endtask

  task automatic t_first_timeout;
    logic [31:0] v;
    set_reload(6);
    wr(A_CTL, 32'h21);
    for (int k = 1; k <= 7; k++) begin
      tick(1);
      rd(A_RAW, v);
      chk($sformatf("R4 raw at k=%0d", k), v, (k >= 6) ? 1 : 0);
      chk($sformatf("R8 trig at k=%0d", k), {31'b0, trig}, (k == 6) ? 1 : 0);
    end
    wr(A_CTL, 0); wr(A_CLR, 32'h7F);
  endtask

  task automatic t_periodic;
    set_reload(3);
    wr(A_CTL, 32'h21);
    for (int k = 1; k <= 9; k++) begin
      tick(1);
      chk($sformatf("R5 periodic trig k=%0d", k), {31'b0, trig}, (k % 3 == 0) ? 1 : 0);
    end
    rdchk("R5 enable stays", A_CTL, 32'h21);
    wr(A_CTL, 32'h01);
    tick(6);
    chk("R8 no trig when bit5 clear", {31'b0, trig}, 0);
    wr(A_CTL, 0); wr(A_CLR, 32'h7F);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(A_MDA, 1);
    set_reload(4);
    wr(A_CTL, 1);
    tick(3);
    rd(A_RAW, v); chk("R6 not yet", v, 0);
    tick(1);
    rd(A_RAW, v); chk("R6 timeout", v, 1);
    rdchk("R6 enable cleared", A_CTL, 0);
    wr(A_CLR, 1);
    tick(10);
    rdchk("R6 no second timeout", A_RAW, 0);
    wr(A_MDA, 0);
  endtask

  task automatic t_mask;
    wr(A_MDA, 1); set_reload(2); wr(A_CTL, 1); tick(3);
    chk("R9 irq low while masked", {31'b0, irq}, 0);
    rdchk("R9 masked zero", A_MIS, 0);
    wr(A_MSK, 1);
    chk("R9 irq high", {31'b0, irq}, 1);
    rdchk("R9 masked one", A_MIS, 1);
    wr(A_CLR, 1);
    chk("R10 irq drops after clear", {31'b0, irq}, 0);
    rdchk("R10 clear reads 0", A_CLR, 0);
    wr(A_MSK, 0); wr(A_MDA, 0);
  endtask

  task automatic t_disable;
    logic [31:0] v;
    set_reload(10);
    wr(A_CTL, 1); tick(5);
    wr(A_CTL, 0); tick(20);
    rdchk("R7 stopped", A_RAW, 0);
    wr(A_CTL, 1);
    tick(9);
    rd(A_RAW, v); chk("R7 restart full count k=9", v, 0);
    tick(1);
    rd(A_RAW, v); chk("R7 restart full count k=10", v, 1);
    wr(A_CTL, 0); wr(A_CLR, 32'h7F);
  endtask

  task automatic t_clear_race;
    logic [31:0] v;
    set_reload(4);
    wr(A_CTL, 1);
    tick(3);
    wr(A_CLR, 1);        // lands on the timeout edge
    rd(A_RAW, v); chk("R10 set wins", v, 1);
    wr(A_CLR, 1);
    rd(A_RAW, v); chk("R10 clear", v, 0);
    wr(A_CTL, 0); wr(A_CLR, 32'h7F);
  endtask

  task automatic t_unmapped;
    wr(A_CFG, 2); wr(A_MSK, 32'h7); wr(A_CFG, 0);
    rdchk("R11 hole 0x10", 8'h10, 0);
    rdchk("R11 hole 0x14", 8'h14, 0);
    rdchk("R11 hole 0x50", 8'h50, 0);
    wr(A_RAW, 32'hFFFF_FFFF); wr(A_MIS, 32'hFFFF_FFFF); wr(8'h10, 32'hFFFF_FFFF);
    rdchk("R11 raw unchanged", A_RAW, 0);
    rdchk("R11 cfg unchanged", A_CFG, 0);
    rdchk("R11 mask unchanged", A_MSK, 32'h7);
    chk("R11 irq unchanged", {31'b0, irq}, 0);
    wr(A_MSK, 0);
  endtask

  task automatic t_gate_zero;
    logic [31:0] v;
    wr(A_CFG, 1); set_reload(3); wr(A_CTL, 1); tick(10);
    rdchk("R12 no count when cfg nonzero", A_RAW, 0);
    wr(A_CTL, 0); wr(A_CFG, 0);
    set_reload(0);
    wr(A_CTL, 1);
    rd(A_RAW, v); chk("R12 zero reload k=0", v, 0);
    tick(1);
    rd(A_RAW, v); chk("R12 zero reload k=1", v, 1);
    wr(A_CTL, 0); wr(A_CLR, 32'h7F);
  endtask

  initial begin
    rst_n = 1'b0; we = 1'b0; re = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_split();
    t_first_timeout();
    t_periodic();
    t_oneshot();
    t_mask();
    t_disable();
    t_clear_race();
    t_unmapped();
    t_gate_zero();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule